// File: doc/BRIEF.md
# Byte-Serial Hamming Code Generator for 256-Byte Flash Blocks

This block computes a single-error-correcting Hamming code over a block of 256 bytes as those bytes cross the flash data window. It does not sit in the data path. It watches the byte strobe of the window and folds each accepted byte into a set of line parities and a column accumulator. Reads and writes through the window count the same way. One control write arms the block for a new block of data. Software then reads the three code bytes back through a small register port and does any correction itself.

The code is 22 bits. Sixteen line-parity bits come from the 8-bit byte index and the XOR of each byte. Six column-parity bits come from bit positions inside the bytes. The code is spread over two line registers and one column register. An optional inversion makes an erased block, where every byte is 0xFF, produce an all-ones code. A byte counter stops accumulation once 256 bytes have been taken. Any bytes after that leave the code alone until the block is armed again.

Top module: `ecc256_gen`

## Requirements
- R1: After reset the control register reads 0x00, both line registers read 0x00 and the column register reads 0x03.
- R2: The control register is at address 0. Bit 0 enables accumulation, bit 1 clears the block and bit 2 selects inverted output. Reading it returns {5'b0, invert, 1'b0, enable}, so the clear bit always reads 0. A write of 0x07 arms a fresh inverted block and 0x03 arms a fresh plain block.
- R3: Take byte i (i = 0..255) with XOR-of-bits parity p. For each index bit k (0..7), p toggles line bit 2k+1 if bit k of i is 1, and line bit 2k if it is 0. Line bits 7:0 read at address 1 and line bits 15:8 read at address 2.
- R4: The column register at address 3 reads {P4, P4', P2, P2', P1, P1', 1, 1}. P(2^j) is the parity, over all accepted bytes, of the bits whose position has bit j set. P(2^j)' covers the bits whose position has bit j clear.
- R5: With the invert bit set, all 16 line bits and the six column parity bits read inverted. The two low column bits still read 1. A block of 256 bytes of 0xFF then reads 0xFF at addresses 1, 2 and 3.
- R6: While the enable bit is 0, data-window strobes change neither the code nor the byte count.
- R7: After 256 accepted bytes, further strobes are ignored until the next clear.
- R8: A write with bit 1 set zeroes the accumulators and the byte counter in that same cycle. A strobe in that same cycle is not counted, and the next accepted byte is index 0.
- R9: Read data is registered. The value for the address presented in one cycle appears on the read port after the next clock edge.
- R10: When one bit of one byte is flipped, the XOR of the new code and the old code has exactly 11 bits set across the 22 code bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dw_stb | input | 1 | One data-window byte transfer this cycle |
| dw_byte | input | 8 | Byte carried by that transfer |
| reg_wr | input | 1 | Write strobe for the register port (only address 0 is writable) |
| reg_sel | input | 2 | Register address: 0 control, 1 line low, 2 line high, 3 column |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data for the previous cycle's address |

## Verification
The code is checked against several data patterns. An all-zero block isolates the constant column bits. An incrementing block makes every line bit depend on its index bit. A pseudo-random block mixes line and column terms, and an all-0xFF block in inverted mode checks the erased-page result. A copy of the random block with one bit flipped shows that a single error moves exactly one bit in each line and column pair. Disabled strobes, a 300-byte overrun and a clear that lands mid-block, in the same cycle as a strobe, tell the gating and the counter apart from the parity logic itself.

// File: rtl/ecc256_pkg.sv
package ecc256_pkg;

  typedef enum logic [1:0] {
    SEL_CTRL    = 2'd0,
    SEL_LINE_LO = 2'd1,
    SEL_LINE_HI = 2'd2,
    SEL_COL     = 2'd3
  } reg_sel_e;

  localparam int CTL_EN_BIT  = 0;
  localparam int CTL_CLR_BIT = 1;
  localparam int CTL_INV_BIT = 2;

  // column parities from the running XOR of all bytes:
  // result = {P4, P4', P2, P2', P1, P1'}
  function automatic logic [5:0] col_from_xor(input logic [7:0] x);
    logic [5:0] r;
    for (int j = 0; j < 3; j++) begin
      logic hi;
      logic lo;
      hi = 1'b0;
      lo = 1'b0;
      for (int b = 0; b < 8; b++) begin
        if (((b >> j) & 1) == 1) hi = hi ^ x[b];
        else                     lo = lo ^ x[b];
      end
      r[2*j+1] = hi;
      r[2*j]   = lo;
    end
    return r;
  endfunction

endpackage

// File: rtl/ecc_blk_cnt.sv
module ecc_blk_cnt #(
  parameter int BLK_BYTES = 256,
  parameter int IDX_W     = $clog2(BLK_BYTES),
  parameter int CNT_W     = $clog2(BLK_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             en,
  input  logic             stb,
  output logic             take,
  output logic [IDX_W-1:0] idx
);

  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(BLK_BYTES);

  logic [CNT_W-1:0] cnt_q;
  logic             full;

  assign full = (cnt_q == LIMIT);
  assign take = en & stb & ~full & ~clr;
  assign idx  = cnt_q[IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (rst || clr) cnt_q <= '0;
    else if (take)  cnt_q <= cnt_q + 1'b1;
  end

  // R7
  cnt_cap_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LIMIT);

  // R8
  cnt_clear_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt_q == '0));

  // R7
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    take |=> (cnt_q == $past(cnt_q) + 1'b1));

endmodule

// File: rtl/ecc_line_acc.sv
module ecc_line_acc #(
  parameter int IDX_W  = 8,
  parameter int LINE_W = 2 * IDX_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              take,
  input  logic [IDX_W-1:0]  idx,
  input  logic [7:0]        byte_in,
  output logic [LINE_W-1:0] lp_q
);

  logic bpar;
  assign bpar = ^byte_in;

  for (genvar k = 0; k < IDX_W; k++) begin : g_pair
    always_ff @(posedge clk) begin
      if (rst || clr) begin
        lp_q[2*k]   <= 1'b0;
        lp_q[2*k+1] <= 1'b0;
      end else if (take) begin
        if (idx[k]) lp_q[2*k+1] <= lp_q[2*k+1] ^ bpar;
        else        lp_q[2*k]   <= lp_q[2*k]   ^ bpar;
      end
    end
  end

  // R6
  line_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!take && !clr) |=> $stable(lp_q));

  // R8
  line_clear_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (lp_q == '0));

endmodule

// File: rtl/ecc_col_acc.sv
module ecc_col_acc (
  input  logic       clk,
  input  logic       rst,
  input  logic       clr,
  input  logic       take,
  input  logic [7:0] byte_in,
  output logic [7:0] colx_q
);

  always_ff @(posedge clk) begin
    if (rst || clr) colx_q <= '0;
    else if (take)  colx_q <= colx_q ^ byte_in;
  end

  // R6
  col_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!take && !clr) |=> $stable(colx_q));

  // R8
  col_clear_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (colx_q == '0));

endmodule

// File: rtl/ecc_regs.sv
module ecc_regs
  import ecc256_pkg::*;
#(
  parameter int LINE_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [1:0]        reg_sel,
  input  logic [7:0]        reg_wdata,
  input  logic [LINE_W-1:0] lp,
  input  logic [7:0]        colx,
  output logic              en,
  output logic              clr,
  output logic [7:0]        rdata
);

  logic       inv_q;
  logic       ctl_wr;
  logic [15:0] line16;
  logic [7:0]  col_reg;
  logic [7:0]  rd_mux;

  assign ctl_wr  = reg_wr && (reg_sel_e'(reg_sel) == SEL_CTRL);
  assign clr     = ctl_wr && reg_wdata[CTL_CLR_BIT];
  assign line16  = 16'(lp);
  assign col_reg = {col_from_xor(colx), 2'b11} ^ {{6{inv_q}}, 2'b00};

  always_ff @(posedge clk) begin
    if (rst) begin
      en    <= 1'b0;
      inv_q <= 1'b0;
    end else if (ctl_wr) begin
      en    <= reg_wdata[CTL_EN_BIT];
      inv_q <= reg_wdata[CTL_INV_BIT];
    end
  end

  always_comb begin
    unique case (reg_sel_e'(reg_sel))
      SEL_CTRL:    rd_mux = {5'b0, inv_q, 1'b0, en};
      SEL_LINE_LO: rd_mux = line16[7:0]  ^ {8{inv_q}};
      SEL_LINE_HI: rd_mux = line16[15:8] ^ {8{inv_q}};
      default:     rd_mux = col_reg;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_mux;
  end

  // R4
  col_spare_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_sel_e'(reg_sel) == SEL_COL) |=> (rdata[1:0] == 2'b11));

endmodule

// File: rtl/ecc256_gen.sv
module ecc256_gen #(
  parameter int BLK_BYTES = 256
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       dw_stb,
  input  logic [7:0] dw_byte,
  input  logic       reg_wr,
  input  logic [1:0] reg_sel,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata
);

  localparam int IDX_W  = $clog2(BLK_BYTES);
  localparam int CNT_W  = $clog2(BLK_BYTES + 1);
  localparam int LINE_W = 2 * IDX_W;

  logic              en;
  logic              clr;
  logic              take;
  logic [IDX_W-1:0]  idx;
  logic [LINE_W-1:0] lp;
  logic [7:0]        colx;

  ecc_regs #(.LINE_W(LINE_W)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .reg_wr   (reg_wr),
    .reg_sel  (reg_sel),
    .reg_wdata(reg_wdata),
    .lp       (lp),
    .colx     (colx),
    .en       (en),
    .clr      (clr),
    .rdata    (reg_rdata)
  );

  ecc_blk_cnt #(.BLK_BYTES(BLK_BYTES), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_cnt (
    .clk (clk),
    .rst (rst),
    .clr (clr),
    .en  (en),
    .stb (dw_stb),
    .take(take),
    .idx (idx)
  );

  ecc_line_acc #(.IDX_W(IDX_W), .LINE_W(LINE_W)) u_line (
    .clk    (clk),
    .rst    (rst),
    .clr    (clr),
    .take   (take),
    .idx    (idx),
    .byte_in(dw_byte),
    .lp_q   (lp)
  );

  ecc_col_acc u_col (
    .clk    (clk),
    .rst    (rst),
    .clr    (clr),
    .take   (take),
    .byte_in(dw_byte),
    .colx_q (colx)
  );

endmodule

// File: tb/ecc256_gen_test.sv
module ecc256_gen_test;

  typedef struct {
    string      tag;
    logic [7:0] val;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       dw_stb = 1'b0;
  logic [7:0] dw_byte = 8'h00;
  logic       reg_wr = 1'b0;
  logic [1:0] reg_sel = 2'd0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  exp_t       exp_q[$];
  logic [7:0] obs_q[$];
  logic [7:0] dat[0:511];
  logic [7:0] last_rd;

  always #2 clk = ~clk;

  ecc256_gen uut (
    .clk(clk), .rst(rst), .dw_stb(dw_stb), .dw_byte(dw_byte),
    .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata)
  );

  // monitor: pairs each observed read with the next expected item
  initial begin
    forever begin
      wait (obs_q.size() != 0);
      begin
        exp_t       e;
        logic [7:0] o;
        e = exp_q.pop_front();
        o = obs_q.pop_front();
        compared++;
        if (o !== e.val) begin
          mismatched++;
          $display("FAIL %s: got %02h expected %02h", e.tag, o, e.val);
        end
      end
    end
  end

  // returns {col, line_hi, line_lo} from the requirement definitions
  function automatic logic [23:0] model(int start, int m, bit inv);
    logic [15:0] ln = '0;
    logic [5:0]  cp = '0;
    logic [7:0]  col;
    for (int i = 0; i < m; i++) begin
      for (int b = 0; b < 8; b++) begin
        if (dat[start+i][b]) begin
          for (int k = 0; k < 8; k++) ln[2*k + ((i >> k) & 1)] ^= 1'b1;
          for (int j = 0; j < 3; j++) cp[2*j + ((b >> j) & 1)] ^= 1'b1;
        end
      end
    end
    col = {cp, 2'b11};
    if (inv) begin
      ln  = ~ln;
      col = col ^ 8'hFC;
    end
    return {col, ln[15:8], ln[7:0]};
  endfunction

  task automatic wr_ctl(input logic [7:0] v);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = 2'd0; reg_wdata = v;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic feed(input int start, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      dw_stb = 1'b1; dw_byte = dat[start+i];
    end
    @(negedge clk);
    dw_stb = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel, input string tag, input logic [7:0] e);
    exp_t it;
    it.tag = tag; it.val = e;
    exp_q.push_back(it);
    @(negedge clk);
    reg_sel = sel;
    @(negedge clk);
    last_rd = reg_rdata;
    obs_q.push_back(reg_rdata);
  endtask

  task automatic rd_code(input string tag, input logic [23:0] e, output logic [23:0] got);
    rd(2'd1, tag, e[7:0]);   got[7:0]   = last_rd;
    rd(2'd2, tag, e[15:8]);  got[15:8]  = last_rd;
    rd(2'd3, tag, e[23:16]); got[23:16] = last_rd;
  endtask

  task automatic scalar_chk(input string tag, input bit ok, input int act, input int expv);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: got %0d expected %0d", tag, act, expv);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [23:0] g0;
    logic [23:0] g1;
    logic [15:0] s;
    s = 16'hACE1;
    for (int i = 0; i < 512; i++) begin
      s = s ^ (s << 7); s = s ^ (s >> 9); s = s ^ (s << 8);
      dat[i] = s[7:0];
    end

    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(2'd0, "R1 ctrl", 8'h00);
    rd_code("R1 code", 24'h03_00_00, g0);

    // R3 R4 zero block, plain mode; R2 control readback
    for (int i = 0; i < 256; i++) dat[300+i%200] = dat[300+i%200];
    wr_ctl(8'h03);
    rd(2'd0, "R2 ctrl plain", 8'h01);
    for (int i = 0; i < 256; i++) begin
      @(negedge clk); dw_stb = 1'b1; dw_byte = 8'h00;
    end
    @(negedge clk); dw_stb = 1'b0;
    rd_code("R4 zero block", 24'h03_00_00, g0);

    // R3 R5 incrementing block, inverted mode (R9 reads back to back)
    begin
      logic [7:0] save[0:255];
      for (int i = 0; i < 256; i++) begin save[i] = dat[i]; dat[i] = 8'(i); end
      wr_ctl(8'h07);
      rd(2'd0, "R2 ctrl inv", 8'h05);
      feed(0, 256);
      rd_code("R3 R9 incrementing inverted", model(0, 256, 1'b1), g0);
      // R5 erased block
      for (int i = 0; i < 256; i++) dat[i] = 8'hFF;
      wr_ctl(8'h07);
      feed(0, 256);
      rd_code("R5 erased", 24'hFF_FF_FF, g0);
      for (int i = 0; i < 256; i++) dat[i] = save[i];
    end

    // R3 R4 random block plain, then R10 single bit flip
    wr_ctl(8'h03);
    feed(0, 256);
    rd_code("R3 random", model(0, 256, 1'b0), g0);
    dat[90] = dat[90] ^ 8'h08;
    wr_ctl(8'h03);
    feed(0, 256);
    rd_code("R10 flipped", model(0, 256, 1'b0), g1);
    scalar_chk("R10 syndrome weight", $countones(g0 ^ g1) == 11, $countones(g0 ^ g1), 11);
    dat[90] = dat[90] ^ 8'h08;

    // R6 disabled: clear only, then strobes
    wr_ctl(8'h02);
    rd(2'd0, "R6 ctrl disabled", 8'h00);
    feed(10, 20);
    rd_code("R6 ignored", 24'h03_00_00, g0);

    // R7 overrun
    wr_ctl(8'h03);
    feed(0, 300);
    rd_code("R7 capped at 256", model(0, 256, 1'b0), g0);

    // R8 clear mid-block, strobe in same cycle dropped
    wr_ctl(8'h03);
    feed(0, 40);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = 2'd0; reg_wdata = 8'h03;
    dw_stb = 1'b1; dw_byte = 8'hA5;
    @(negedge clk);
    reg_wr = 1'b0; dw_stb = 1'b0;
    feed(40, 100);
    rd_code("R8 clear restarts", model(40, 100, 1'b0), g0);

    wait (obs_q.size() == 0);
    @(negedge clk);
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule